// File: doc/BRIEF.md
# Dual-Bank Wide Operand Register File

This block stores the wide operands of an extension-instruction datapath: 32 registers of 128 bits, held as two banks of 16 (bank A and bank B). Three read ports can each reach any of the 32 registers in the same cycle. Reads are combinational, so an issuing instruction gets up to three 128-bit sources without waiting.

Two write ports store up to two results per cycle. Each write port is wired to one bank only: port A to bank A and port B to bank B. Because of this, the two writes can never collide and the file needs no arbitration between them. A register may be a source and a destination of the same operation. The read then sees the stored value, unless the forwarding input is high, in which case it sees the value being written.

A synchronous reset zeroes every register. An address whose bank bit is 0 lands in bank A, so bank A is the default bank.

Top module: `wide_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every one of the 32 registers becomes zero, and all of them read as zero afterwards.
- R2: A 5-bit read address uses bit 4 as the bank bit (0 is bank A, 1 is bank B) and bits 3:0 as the index within that bank. Each of the three read ports can reach all 32 registers.
- R3: When `wa_en` is high at a rising edge, `wa_data` is stored in bank A at index `wa_idx`. The value is readable from the next cycle.
- R4: Write port B stores `wb_data` in bank B at index `wb_idx` when `wb_en` is high. It never changes any register of bank A.
- R5: Both write ports may be enabled in the same cycle, including with equal indices, and both writes take effect.
- R6: The three read ports work independently and combinationally. Each returns the register its own address selects in the same cycle.
- R7: With `fwd_en` low, a read of a register that is being written in the current cycle returns the value stored before that write.
- R8: With `fwd_en` high, a read of a register that is being written in the current cycle returns the data being written.
- R9: A write port whose enable is low changes no register, whatever its index and data are.
- R10: Reset takes priority over writes that are enabled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fwd_en | input | 1 | Forward same-cycle write data to matching reads |
| rd_addr0 | input | 5 | Read port 0 address (bit 4 bank, bits 3:0 index) |
| rd_addr1 | input | 5 | Read port 1 address |
| rd_addr2 | input | 5 | Read port 2 address |
| rd_data0 | output | 128 | Read port 0 data |
| rd_data1 | output | 128 | Read port 1 data |
| rd_data2 | output | 128 | Read port 2 data |
| wa_en | input | 1 | Bank A write enable |
| wa_idx | input | 4 | Bank A write index |
| wa_data | input | 128 | Bank A write data |
| wb_en | input | 1 | Bank B write enable |
| wb_idx | input | 4 | Bank B write index |
| wb_data | input | 128 | Bank B write data |

## Verification
Directed cases cover the following:
- Writes to the same index in both banks. These show whether the bank bit really separates A from B and whether two writes in one cycle both land.
- A write on port B alone. This exposes any leak into bank A.
- Enables held low while data and index toggle.
- A read of the register being written, tried once with forwarding off and once with it on. This separates old-value from new-value behaviour.
- Writes held during reset.

A long random phase then drives three independent addresses with enables and the forwarding flag chosen at random. Write indices are biased to hit the read addresses about half of the time, so many cycles exercise the forwarding path. Every port is compared each cycle against a bench model.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int WRF_DATA_W        = 128;
    localparam int WRF_REGS_PER_BANK = 16;
    localparam int WRF_NUM_RD        = 3;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } wrf_bank_e;

endpackage

// File: rtl/wrf_bank.sv
module wrf_bank #(
    parameter int DATA_W = wrf_pkg::WRF_DATA_W,
    parameter int DEPTH  = wrf_pkg::WRF_REGS_PER_BANK,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] regs_q [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic hit;
        assign hit = we && (widx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (hit) begin
                regs_q[g] <= wdata;
            end
        end

        // R1: register is zero once reset is released
        a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (regs_q[g] == '0));

        // R3: an enabled write lands in the addressed entry
        a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
            (we && widx == IDX_W'(g)) |=> (regs_q[g] == $past(wdata)));

        // R9: an entry not addressed by an enabled write keeps its value
        a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
            !(we && widx == IDX_W'(g)) |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port #(
    parameter int DATA_W  = wrf_pkg::WRF_DATA_W,
    parameter int DEPTH   = wrf_pkg::WRF_REGS_PER_BANK,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwd_en,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] bank_a_q [DEPTH],
    input  logic [DATA_W-1:0] bank_b_q [DEPTH],
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] rdata
);
    import wrf_pkg::*;

    wrf_bank_e         bank_sel;
    logic [IDX_W-1:0]  ridx;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] fwd_word;
    logic              wr_hit;

    always_comb begin
        bank_sel = wrf_bank_e'(raddr[ADDR_W-1]);
        ridx     = raddr[IDX_W-1:0];
        unique case (bank_sel)
            BANK_A: begin
                stored   = bank_a_q[ridx];
                fwd_word = wa_data;
                wr_hit   = wa_en && (wa_idx == ridx);
            end
            BANK_B: begin
                stored   = bank_b_q[ridx];
                fwd_word = wb_data;
                wr_hit   = wb_en && (wb_idx == ridx);
            end
            default: begin
                stored   = '0;
                fwd_word = '0;
                wr_hit   = 1'b0;
            end
        endcase
        rdata = (fwd_en && wr_hit) ? fwd_word : stored;
    end

    // R8: forwarding returns the bank A write data on a match
    a_r8_fwd_bank_a: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && !raddr[ADDR_W-1] && wa_en && wa_idx == raddr[IDX_W-1:0])
            |-> (rdata == wa_data));

    // R8: forwarding returns the bank B write data on a match
    a_r8_fwd_bank_b: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && raddr[ADDR_W-1] && wb_en && wb_idx == raddr[IDX_W-1:0])
            |-> (rdata == wb_data));

endmodule

// File: rtl/wide_regfile.sv
module wide_regfile #(
    parameter int DATA_W  = wrf_pkg::WRF_DATA_W,
    parameter int DEPTH   = wrf_pkg::WRF_REGS_PER_BANK,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwd_en,
    input  logic [ADDR_W-1:0] rd_addr0,
    input  logic [ADDR_W-1:0] rd_addr1,
    input  logic [ADDR_W-1:0] rd_addr2,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    output logic [DATA_W-1:0] rd_data2,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data
);
    localparam int NUM_RD = wrf_pkg::WRF_NUM_RD;

    logic [DATA_W-1:0] bank_a_q [DEPTH];
    logic [DATA_W-1:0] bank_b_q [DEPTH];
    logic [ADDR_W-1:0] rd_addr_arr [NUM_RD];
    logic [DATA_W-1:0] rd_data_arr [NUM_RD];

    wrf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank_a (
        .clk   (clk),
        .rst   (rst),
        .we    (wa_en),
        .widx  (wa_idx),
        .wdata (wa_data),
        .regs_q(bank_a_q)
    );

    wrf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank_b (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_en),
        .widx  (wb_idx),
        .wdata (wb_data),
        .regs_q(bank_b_q)
    );

    assign rd_addr_arr[0] = rd_addr0;
    assign rd_addr_arr[1] = rd_addr1;
    assign rd_addr_arr[2] = rd_addr2;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        wrf_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_port (
            .clk     (clk),
            .rst     (rst),
            .fwd_en  (fwd_en),
            .raddr   (rd_addr_arr[p]),
            .bank_a_q(bank_a_q),
            .bank_b_q(bank_b_q),
            .wa_en   (wa_en),
            .wa_idx  (wa_idx),
            .wa_data (wa_data),
            .wb_en   (wb_en),
            .wb_idx  (wb_idx),
            .wb_data (wb_data),
            .rdata   (rd_data_arr[p])
        );
    end

    assign rd_data0 = rd_data_arr[0];
    assign rd_data1 = rd_data_arr[1];
    assign rd_data2 = rd_data_arr[2];

    // R5: two writes in one cycle both land in their own banks
    a_r5_dual_write: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |=>
            (bank_a_q[$past(wa_idx)] == $past(wa_data)) &&
            (bank_b_q[$past(wb_idx)] == $past(wb_data)));

    // R7: without forwarding, a colliding read does not see new data
    a_r7_old_value: assert property (@(posedge clk) disable iff (rst)
        (!fwd_en && !rd_addr0[ADDR_W-1] && wa_en &&
         wa_idx == rd_addr0[IDX_W-1:0] && wa_data != bank_a_q[wa_idx])
            |-> (rd_data0 != wa_data));

endmodule

// File: tb/tb_wide_regfile.sv
`timescale 1ns/1ps
module tb_wide_regfile;

    localparam int DW = 128;
    localparam int NREG = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          fwd_en;
    logic [4:0]    rd_addr0, rd_addr1, rd_addr2;
    logic [DW-1:0] rd_data0, rd_data1, rd_data2;
    logic          wa_en, wb_en;
    logic [3:0]    wa_idx, wb_idx;
    logic [DW-1:0] wa_data, wb_data;

    logic [DW-1:0] model [NREG];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    wide_regfile dut (
        .clk(clk), .rst(rst), .fwd_en(fwd_en),
        .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_addr2(rd_addr2),
        .rd_data0(rd_data0), .rd_data1(rd_data1), .rd_data2(rd_data2),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [DW-1:0] predict(logic [4:0] a);
        if (fwd_en && !a[4] && wa_en && wa_idx == a[3:0]) return wa_data;
        if (fwd_en &&  a[4] && wb_en && wb_idx == a[3:0]) return wb_data;
        return model[a];
    endfunction

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_reads(string req);
        #1;
        chk(req, rd_data0, predict(rd_addr0));
        chk(req, rd_data1, predict(rd_addr1));
        chk(req, rd_data2, predict(rd_addr2));
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NREG; i++) model[i] = '0;
        end else begin
            if (wa_en) model[{1'b0, wa_idx}] = wa_data;
            if (wb_en) model[{1'b1, wb_idx}] = wb_data;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wa_en = 1'b0; wb_en = 1'b0;
        wa_idx = '0; wb_idx = '0;
        wa_data = '0; wb_data = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        for (int i = 0; i < NREG; i++) model[i] = 'x;
        rst = 1'b1; fwd_en = 1'b0;
        rd_addr0 = '0; rd_addr1 = '0; rd_addr2 = '0;
        idle();
        @(negedge clk);
        // R10: writes enabled while reset is asserted are overridden
        wa_en = 1'b1; wa_idx = 4'd2; wa_data = rnd_word();
        wb_en = 1'b1; wb_idx = 4'd9; wb_data = rnd_word();
        step();
        step();
        rst = 1'b0;
        idle();
        // R1: all 32 registers read zero after reset
        for (int a = 0; a < NREG; a++) begin
            rd_addr0 = 5'(a);
            #1 chk("R1", rd_data0, '0);
        end
        rd_addr0 = 5'd2;  rd_addr1 = 5'd25; rd_addr2 = 5'd18;
        #1;
        chk("R10", rd_data0, '0);
        chk("R10", rd_data1, '0);

        // R5: both ports, same index 3
        wa_en = 1'b1; wa_idx = 4'd3; wa_data = rnd_word();
        wb_en = 1'b1; wb_idx = 4'd3; wb_data = rnd_word();
        step();
        idle();
        rd_addr0 = 5'd3; rd_addr1 = 5'd19; rd_addr2 = 5'd3;
        check_reads("R5");
        chk("R2", rd_data0, model[3]);
        chk("R2", rd_data1, model[19]);

        // R4: port B only; bank A index 7 must stay zero
        wb_en = 1'b1; wb_idx = 4'd7; wb_data = rnd_word();
        step();
        idle();
        rd_addr0 = 5'd7; rd_addr1 = 5'd23; rd_addr2 = 5'd7;
        #1;
        chk("R4", rd_data0, '0);
        chk("R4", rd_data1, model[23]);

        // R3: port A write, visible next cycle on every port
        wa_en = 1'b1; wa_idx = 4'd12; wa_data = rnd_word();
        step();
        idle();
        rd_addr0 = 5'd12; rd_addr1 = 5'd12; rd_addr2 = 5'd28;
        check_reads("R3");

        // R9: enables low, index and data toggling
        for (int k = 0; k < 4; k++) begin
            wa_idx = 4'd12; wa_data = rnd_word();
            wb_idx = 4'd7;  wb_data = rnd_word();
            step();
        end
        rd_addr0 = 5'd12; rd_addr1 = 5'd23; rd_addr2 = 5'd3;
        check_reads("R9");

        // R7: same-cycle collision without forwarding returns old value
        fwd_en = 1'b0;
        wa_en = 1'b1; wa_idx = 4'd12; wa_data = rnd_word();
        wb_en = 1'b1; wb_idx = 4'd7;  wb_data = rnd_word();
        rd_addr0 = 5'd12; rd_addr1 = 5'd23; rd_addr2 = 5'd12;
        check_reads("R7");
        step();

        // R8: same-cycle collision with forwarding returns new data
        fwd_en = 1'b1;
        wa_en = 1'b1; wa_idx = 4'd12; wa_data = rnd_word();
        wb_en = 1'b1; wb_idx = 4'd7;  wb_data = rnd_word();
        check_reads("R8");
        #1 chk("R8", rd_data0, wa_data);
        chk("R8", rd_data1, wb_data);
        step();
        idle();
        fwd_en = 1'b0;
        check_reads("R8");

        // R6: random traffic on all ports
        for (int c = 0; c < 600; c++) begin
            rd_addr0 = 5'($urandom_range(0, 31));
            rd_addr1 = 5'($urandom_range(0, 31));
            rd_addr2 = 5'($urandom_range(0, 31));
            fwd_en   = 1'($urandom_range(0, 1));
            wa_en    = ($urandom_range(0, 3) != 0);
            wb_en    = ($urandom_range(0, 3) != 0);
            wa_idx   = $urandom_range(0, 1) ? rd_addr0[3:0] : 4'($urandom_range(0, 15));
            wb_idx   = $urandom_range(0, 1) ? rd_addr1[3:0] : 4'($urandom_range(0, 15));
            wa_data  = rnd_word();
            wb_data  = rnd_word();
            check_reads("R6");
            step();
        end
        idle();
        fwd_en = 1'b0;
        for (int a = 0; a < NREG; a++) begin
            rd_addr2 = 5'(a);
            #1 chk("R2", rd_data2, model[a]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule